// File: doc/BRIEF.md
# Registered Eight-Operation ALU with Status Flags

This block is an integer arithmetic and logic unit for a W-bit datapath (8 bits by default). Two operand registers, A and B, are written from their own data inputs whenever the matching load strobe is high. On every rising clock edge the unit applies the operation chosen by a 3-bit opcode to the values then held in A and B. It writes the result into the result register X and writes a 4-bit status word computed from that same result into the flag register.

The opcode is a plain input and is not registered. A caller can therefore run a new operation on the same operands every cycle, or load fresh operands and run an operation one cycle later. Subtraction, addition and the two shifts report a carry. The two arithmetic operations also report signed overflow. The bitwise operations and the shifts always report no overflow.

Top module: `flag_alu`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), A, B and X are all zero and the flag word is 4'b0100, which is Zero set and every other flag clear.
- R2: An operand register takes its data input on a clock edge where its load strobe is high. Otherwise it keeps its value, whatever is on its data input.
- R3: Opcode 3'b000 (add) stores A+B modulo 2^W in X. Flag bit 1 (carry) is the carry out of the most significant bit.
- R4: Opcode 3'b001 (subtract) stores A-B modulo 2^W in X. Flag bit 1 is set exactly when A < B as unsigned numbers (borrow).
- R5: Opcodes 3'b100 (AND), 3'b101 (OR) and 3'b111 (XOR) combine A and B bit by bit. Opcode 3'b110 stores the inverse of A. For all four, flag bits 1 and 3 are cleared.
- R6: Opcode 3'b010 shifts A left by one and 3'b011 shifts A right by one, each filling with zero. Flag bit 1 takes the bit shifted out, and flag bit 3 is cleared.
- R7: Flag bit 0 (sign) equals the most significant bit of the stored result.
- R8: Flag bit 2 (zero) is set exactly when the stored result is all zeros.
- R9: For add, flag bit 3 (overflow) is set when A and B have the same sign bit and the result's sign bit differs from it.
- R10: For subtract, flag bit 3 is set when A and B have different sign bits and the result's sign bit differs from A's.
- R11: X and the flags change only at a clock edge. They reflect the opcode present at that edge and the contents of A and B before that edge, so a result is ready one cycle after its opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_din | input | W | Data for operand register A |
| a_ld | input | 1 | Load strobe for A |
| b_din | input | W | Data for operand register B |
| b_ld | input | 1 | Load strobe for B |
| op | input | 3 | Operation select |
| x_out | output | W | Result register X |
| flags_out | output | 4 | Flags: bit0 sign, bit1 carry, bit2 zero, bit3 overflow |

## Verification
When the opcode alone changes, its result is due at the first clock edge after the change. When operands are loaded together with an opcode, the result is due at the second edge, because the first edge only fills A and B. The driver holds each stimulus for exactly that many edges and then queues the expected X and flags. The monitor compares them on the following falling edge, so every comparison falls half a cycle after the register that feeds it has been written.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_SHL = 3'b010,
    OP_SHR = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_INV = 3'b110,
    OP_XOR = 3'b111
  } alu_op_e;

  localparam int FLG_S = 0;
  localparam int FLG_C = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;
endpackage

// File: rtl/opnd_reg.sv
module opnd_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  // R2: value is kept when the strobe is low
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
  a_r2_take_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(d));
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic sign_flip(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  // named internal events
  logic [W:0]   add_full, sub_full;
  logic         add_cout, sub_borrow, shl_out, shr_out;
  logic         add_ovf, sub_ovf;
  logic [W-1:0] shl_val, shr_val;

  assign add_full   = add_ext(a, b, 1'b0);
  assign sub_full   = add_ext(a, ~b, 1'b1);
  assign add_cout   = add_full[W];
  assign sub_borrow = ~sub_full[W];
  assign shl_val    = {a[MSB-1:0], 1'b0};
  assign shr_val    = {1'b0, a[MSB:1]};
  assign shl_out    = a[MSB];
  assign shr_out    = a[0];
  assign add_ovf    = sign_flip(a[MSB], b[MSB], add_full[MSB]);
  // a - b overflows as a + (~b): operand signs a and ~b must agree
  assign sub_ovf    = sign_flip(a[MSB], ~b[MSB], sub_full[MSB]);

  always_comb begin
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    unique case (op)
      OP_ADD: begin res = add_full[W-1:0]; carry = add_cout;   ovf = add_ovf; end
      OP_SUB: begin res = sub_full[W-1:0]; carry = sub_borrow; ovf = sub_ovf; end
      OP_SHL: begin res = shl_val; carry = shl_out; end
      OP_SHR: begin res = shr_val; carry = shr_out; end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_INV: res = ~a;
      OP_XOR: res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/result_reg.sv
module result_reg
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     res,
  input  logic             carry,
  input  logic             ovf,
  output logic [W-1:0]     x_q,
  output logic [FLG_W-1:0] flg_q
);
  logic [FLG_W-1:0] flg_next;

  always_comb begin
    flg_next        = '0;
    flg_next[FLG_S] = res[W-1];
    flg_next[FLG_C] = carry;
    flg_next[FLG_Z] = (res == '0);
    flg_next[FLG_V] = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      flg_q <= 4'b0100;
    end else begin
      x_q   <= res;
      flg_q <= flg_next;
    end
  end

  // R7 / R8: status bits agree with the stored result at all times
  a_r7_sign_tracks_x: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q[FLG_S] == x_q[W-1]);
  a_r8_zero_tracks_x: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q[FLG_Z] == (x_q == '0));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_din,
  input  logic         a_ld,
  input  logic [W-1:0] b_din,
  input  logic         b_ld,
  input  logic [2:0]   op,
  output logic [W-1:0] x_out,
  output logic [3:0]   flags_out
);
  localparam int NOPND = 2;

  logic [W-1:0] opnd_d [NOPND];
  logic         opnd_ld[NOPND];
  logic [W-1:0] opnd_q [NOPND];
  logic [W-1:0] a_q, b_q, res;
  logic         carry, ovf;
  alu_op_e      op_e;

  assign opnd_d[0]  = a_din;
  assign opnd_d[1]  = b_din;
  assign opnd_ld[0] = a_ld;
  assign opnd_ld[1] = b_ld;
  assign a_q        = opnd_q[0];
  assign b_q        = opnd_q[1];
  assign op_e       = alu_op_e'(op);

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    opnd_reg #(.W(W)) u_reg (
      .clk(clk), .rst_n(rst_n), .ld(opnd_ld[i]), .d(opnd_d[i]), .q(opnd_q[i])
    );
  end

  alu_datapath #(.W(W)) u_dp (
    .a(a_q), .b(b_q), .op(op_e), .res(res), .carry(carry), .ovf(ovf)
  );

  result_reg #(.W(W)) u_res (
    .clk(clk), .rst_n(rst_n), .res(res), .carry(carry), .ovf(ovf),
    .x_q(x_out), .flg_q(flags_out)
  );

  // R5: bitwise ops leave carry and overflow clear
  a_r5_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (op[2] == 1'b1) |=> (flags_out[FLG_C] == 1'b0 && flags_out[FLG_V] == 1'b0));
  // R6: left shift reports the old top bit of A
  a_r6_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b010) |=> (flags_out[FLG_C] == $past(a_q[W-1]) && !flags_out[FLG_V]));
  a_r6_shr_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b011) |=> (flags_out[FLG_C] == $past(a_q[0]) && !flags_out[FLG_V]));
  // R9: same-sign add, result sign tells overflow
  a_r9_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b000 && a_q[W-1] == b_q[W-1])
      |=> flags_out[FLG_V] == (x_out[W-1] != $past(a_q[W-1])));
  // R10: differing-sign subtract
  a_r10_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b001 && a_q[W-1] != b_q[W-1])
      |=> flags_out[FLG_V] == (x_out[W-1] != $past(a_q[W-1])));
  // R4: borrow equals unsigned compare
  a_r4_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b001) |=> flags_out[FLG_C] == ($past(a_q) < $past(b_q)));
endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_din = '0, b_din = '0;
  logic       a_ld = 1'b0, b_ld = 1'b0;
  logic [2:0] op = 3'b100;
  logic [7:0] x_out;
  logic [3:0] flags_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] ma = '0, mb = '0;  // bench's own copy of the operands

  typedef struct { string tag; logic [7:0] x; logic [3:0] f; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  flag_alu u0 (
    .clk(clk), .rst_n(rst_n), .a_din(a_din), .a_ld(a_ld), .b_din(b_din), .b_ld(b_ld),
    .op(op), .x_out(x_out), .flags_out(flags_out)
  );

  function automatic logic [11:0] model(input logic [2:0] o, input logic [7:0] a,
                                        input logic [7:0] b);
    int s;
    logic [7:0] r;
    logic c, v;
    c = 0; v = 0; r = 0;
    case (o)
      3'd0: begin s = int'(a) + int'(b); r = s[7:0]; c = (s > 255);
                  v = (a[7] == b[7]) && (r[7] != a[7]); end
      3'd1: begin s = int'(a) - int'(b); r = s[7:0]; c = (a < b);
                  v = (a[7] != b[7]) && (r[7] != a[7]); end
      3'd2: begin r = a << 1; c = a[7]; end
      3'd3: begin r = a >> 1; c = a[0]; end
      3'd4: r = a & b;
      3'd5: r = a | b;
      3'd6: r = ~a;
      default: r = a ^ b;
    endcase
    return {v, (r == 8'h00), c, r[7], r};
  endfunction

  task automatic push(input string tag);
    exp_t e;
    logic [11:0] m;
    m = model(op, ma, mb);
    e.tag = tag; e.x = m[7:0]; e.f = m[11:8];
    q.push_back(e);
  endtask

  // load operands (as selected) with an opcode; result due two edges later
  task automatic load_op(input logic [7:0] a, input logic la, input logic [7:0] b,
                         input logic lb, input logic [2:0] o, input string tag);
    @(negedge clk);
    a_din = a; b_din = b; a_ld = la; b_ld = lb; op = o;
    @(posedge clk);
    if (la) ma = a;
    if (lb) mb = b;
    @(negedge clk);
    a_ld = 0; b_ld = 0;
    @(posedge clk); #1;
    push(tag);
  endtask

  // new opcode only; result due at the next edge
  task automatic step_op(input logic [2:0] o, input string tag);
    @(negedge clk);
    op = o;
    @(posedge clk); #1;
    push(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (x_out !== e.x || flags_out !== e.f) begin
          bad++;
          $display("FAIL %s: x=%h flags=%b expected x=%h flags=%b",
                   e.tag, x_out, flags_out, e.x, e.f);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: x=%h flags=%b expected completion", x_out, flags_out);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    total++;  // R1: reset state
    if (x_out !== 8'h00 || flags_out !== 4'b0100) begin
      bad++;
      $display("FAIL R1: x=%h flags=%b expected x=00 flags=0100", x_out, flags_out);
    end
    @(negedge clk); rst_n = 1;

    load_op(8'd3,  1, 8'd4,  1, 3'd0, "R3 plain add");
    load_op(8'hFF, 1, 8'h01, 1, 3'd0, "R3/R8 add wraps to zero");
    load_op(8'h7F, 1, 8'h01, 1, 3'd0, "R9/R7 positive overflow");
    load_op(8'h80, 1, 8'h80, 1, 3'd0, "R9 negative overflow");
    load_op(8'h05, 1, 8'h05, 1, 3'd1, "R4/R8 equal subtract");
    load_op(8'h03, 1, 8'h05, 1, 3'd1, "R4 borrow");
    load_op(8'h80, 1, 8'h01, 1, 3'd1, "R10 overflow neg-pos");
    load_op(8'h7F, 1, 8'hFF, 1, 3'd1, "R10 overflow pos-neg");
    load_op(8'hF0, 1, 8'h10, 1, 3'd1, "R10 no overflow");
    load_op(8'hC5, 1, 8'h5C, 1, 3'd4, "R5 AND");
    step_op(3'd0, "R11 add same operands");
    step_op(3'd5, "R5 OR clears carry");
    step_op(3'd7, "R5 XOR");
    step_op(3'd6, "R5 NOT of A");
    load_op(8'h81, 1, 8'h00, 0, 3'd2, "R6 shift left carry out");
    step_op(3'd3, "R6 shift right carry out");
    load_op(8'h01, 1, 8'h00, 0, 3'd3, "R6/R8 shift right to zero");
    load_op(8'h40, 1, 8'h00, 0, 3'd2, "R6/R7 shift left into sign");
    load_op(8'h22, 0, 8'h0F, 1, 3'd5, "R2 only B loaded");
    load_op(8'hAA, 0, 8'h99, 0, 3'd7, "R2 no load holds A and B");
    step_op(3'd1, "R11 back-to-back subtract");
    step_op(3'd0, "R11 back-to-back add");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule